// File: doc/BRIEF.md
# TLB Invalidation Sequencer

This unit sits beside the instruction retirement path and handles the fine-grained address-translation invalidation instructions. It takes each SYSTEM-opcode instruction together with the current privilege level, the trap-virtual-memory bit and a hypervisor-enable setting. For each one it does exactly one of three things. It raises an illegal-instruction trap. It sends an invalidate request to the TLB. Or it enters one of two ordering fences that wait on outside agents.

Invalidates go out back to back with no pipeline drain between them, so the TLB may still be working on several at once. Ordering is enforced only at two points. The leading fence holds retirement until the store buffer reports that every earlier store is visible. The trailing fence holds retirement, and keeps the page walker from starting new page-table references, until the TLB's pending-invalidate count reaches zero. The leading fence makes sure page-table updates land before the invalidates that follow it. The trailing fence makes sure those invalidates take effect before any later walk.

Top module: `tlb_inval_seq`

## Requirements
- R1: After reset, busy, sb_drain_req, walk_hold, inv_valid and illegal_trap are all low, and insn_ready is high.
- R2: A legal instruction with opcode 1110011, funct3 000, rd field 0 and funct7 0001011 drives inv_valid with inv_stage 00, inv_addr equal to rs1_val and inv_id equal to the low ID_W bits of rs2_val. inv_all_addr is high exactly when the rs1 field (bits 19:15) is zero. inv_all_id is high exactly when the rs2 field (bits 24:20) is zero.
- R3: With hyp_en high, funct7 0010011 issues an invalidate with inv_stage 01, where the ID is a guest address-space ID. funct7 0110011 issues one with inv_stage 10, where the ID is a virtual-machine ID. In both cases the fields are filled as in R2.
- R4: Invalidates are accepted on consecutive cycles while inv_pending is non-zero, and busy stays low throughout.
- R5: While an invalidate is presented and inv_ready is low, inv_valid stays high and insn_ready stays low.
- R6: Accepting funct7 0001100 with rs2 field 0 raises sb_drain_req and busy from the next cycle. Both stay high, and insn_ready stays low, through the first cycle in which sb_drained is seen high. They return to idle on the cycle after that.
- R7: Accepting funct7 0001100 with rs2 field 1 raises walk_hold and busy from the next cycle. Both stay high, and insn_ready stays low, through the first cycle in which inv_pending is seen at zero.
- R8: In user mode (priv 00), every one of the five forms raises illegal_trap and produces no request and no fence.
- R9: In supervisor mode (priv 01) with tvm high, funct7 0001011 traps. The two fence forms still execute normally. In machine mode (priv 11), tvm has no effect.
- R10: With hyp_en low, both hypervisor invalidate forms trap.
- R11: Any of the recognised funct7 values with a non-zero rd field traps. funct7 0001100 with an rs2 field other than 0 or 1 also traps.
- R12: An instruction whose opcode, funct3 or funct7 is not one of the above is consumed with no trap, no request and no fence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| insn_valid | input | 1 | An instruction is presented |
| insn | input | 32 | Instruction word |
| rs1_val | input | XLEN | Value of the rs1 register (address) |
| rs2_val | input | XLEN | Value of the rs2 register (address-space or VM ID) |
| priv | input | 2 | Privilege: 00 user, 01 supervisor, 11 machine |
| tvm | input | 1 | Trap-virtual-memory bit |
| hyp_en | input | 1 | Hypervisor extension enabled |
| insn_ready | output | 1 | The presented instruction is consumed this cycle |
| busy | output | 1 | A fence is waiting, so retirement is stalled |
| illegal_trap | output | 1 | The presented instruction raises an illegal-instruction trap |
| inv_valid | output | 1 | Invalidate request to the TLB |
| inv_ready | input | 1 | TLB accepts the invalidate |
| inv_addr | output | XLEN | Invalidate address |
| inv_id | output | ID_W | Address-space or VM ID |
| inv_stage | output | 2 | 00 supervisor, 01 guest, 10 G-stage |
| inv_all_addr | output | 1 | Match all addresses |
| inv_all_id | output | 1 | Match all IDs |
| inv_pending | input | CNT_W | Invalidates the TLB has accepted but not yet completed |
| sb_drain_req | output | 1 | Request to make all earlier stores visible |
| sb_drained | input | 1 | Store buffer reports that all earlier stores are visible |
| walk_hold | output | 1 | Page walker must not start new references |

## Verification
The main function is tried with single invalidates in all three stages. It is also tried with a run of invalidates issued while earlier ones are still pending, with invalidates held off by inv_ready, and with each fence blocking a following invalidate for several cycles before its condition is met. The back-to-back run separates a design that pipelines invalidates from one that drains at each of them. The blocked invalidates during a fence show that the fences order the invalidates correctly. Permission cases cross privilege level, tvm and hyp_en against every form. These separate the trap rule for the invalidate from the trap rules for the two fences. A reference model in the bench predicts every output on every cycle.

// File: rtl/tlb_inval_seq.sv
module tlb_inval_seq #(
  parameter int XLEN  = 64,
  parameter int ID_W  = 16,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             insn_valid,
  input  logic [31:0]      insn,
  input  logic [XLEN-1:0]  rs1_val,
  input  logic [XLEN-1:0]  rs2_val,
  input  logic [1:0]       priv,
  input  logic             tvm,
  input  logic             hyp_en,
  output logic             insn_ready,
  output logic             busy,
  output logic             illegal_trap,
  output logic             inv_valid,
  input  logic             inv_ready,
  output logic [XLEN-1:0]  inv_addr,
  output logic [ID_W-1:0]  inv_id,
  output logic [1:0]       inv_stage,
  output logic             inv_all_addr,
  output logic             inv_all_id,
  input  logic [CNT_W-1:0] inv_pending,
  output logic             sb_drain_req,
  input  logic             sb_drained,
  output logic             walk_hold
);

  localparam logic [6:0] OPC_SYS  = 7'b1110011;
  localparam logic [6:0] F7_SINV  = 7'b0001011;
  localparam logic [6:0] F7_FENCE = 7'b0001100;
  localparam logic [6:0] F7_HVV   = 7'b0010011;
  localparam logic [6:0] F7_HGV   = 7'b0110011;
  localparam logic [1:0] PRIV_U   = 2'b00;
  localparam logic [1:0] PRIV_S   = 2'b01;

  typedef enum logic [1:0] {ST_IDLE, ST_STORES, ST_INVS} seq_st_e;
  seq_st_e st_q, st_d;

  logic [6:0] f7;
  logic [4:0] rs1_f, rs2_f, rd_f;
  logic       sys_hit, k_sinv, k_hvv, k_hgv, k_fw, k_fir, k_fbad, k_any;
  logic       bad, idle, do_inv, do_fw, do_fir;

  assign f7    = insn[31:25];
  assign rs2_f = insn[24:20];
  assign rs1_f = insn[19:15];
  assign rd_f  = insn[11:7];

  assign sys_hit = insn_valid && insn[6:0] == OPC_SYS && insn[14:12] == 3'b000;
  assign k_sinv  = sys_hit && f7 == F7_SINV;
  assign k_hvv   = sys_hit && f7 == F7_HVV;
  assign k_hgv   = sys_hit && f7 == F7_HGV;
  assign k_fw    = sys_hit && f7 == F7_FENCE && rs2_f == 5'd0;
  assign k_fir   = sys_hit && f7 == F7_FENCE && rs2_f == 5'd1;
  assign k_fbad  = sys_hit && f7 == F7_FENCE && rs2_f > 5'd1;
  assign k_any   = k_sinv | k_hvv | k_hgv | k_fw | k_fir | k_fbad;

  assign bad = k_fbad
             | (k_any && rd_f != 5'd0)
             | (k_any && priv == PRIV_U)
             | (k_sinv && priv == PRIV_S && tvm)
             | ((k_hvv | k_hgv) && !hyp_en);

  assign idle   = st_q == ST_IDLE;
  assign do_inv = (k_sinv | k_hvv | k_hgv) && !bad;
  assign do_fw  = idle && k_fw && !bad;
  assign do_fir = idle && k_fir && !bad;

  assign inv_valid    = idle && do_inv;
  assign illegal_trap = idle && bad;
  assign insn_ready   = idle && (!do_inv || inv_ready);
  assign busy         = !idle;
  assign sb_drain_req = st_q == ST_STORES;
  assign walk_hold    = st_q == ST_INVS;

  assign inv_addr     = rs1_val;
  assign inv_id       = rs2_val[ID_W-1:0];
  assign inv_all_addr = rs1_f == 5'd0;
  assign inv_all_id   = rs2_f == 5'd0;
  assign inv_stage    = k_hgv ? 2'b10 : (k_hvv ? 2'b01 : 2'b00);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:   if (do_fw) st_d = ST_STORES;
                 else if (do_fir) st_d = ST_INVS;
      ST_STORES: if (sb_drained) st_d = ST_IDLE;
      ST_INVS:   if (inv_pending == '0) st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;

  // R4
  no_inv_in_fence_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !inv_valid);

  // R5
  inv_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid && !inv_ready |-> !insn_ready);

  // R6
  drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sb_drain_req && !sb_drained |=> sb_drain_req);

  // R7
  walk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_hold && inv_pending != '0 |=> walk_hold);

  // R7
  walk_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_hold && inv_pending == '0 |=> !walk_hold);

  // R8
  user_no_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> priv != PRIV_U);

  // R9
  tvm_no_sinv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid && inv_stage == 2'b00 |-> !(priv == PRIV_S && tvm));

  // R10
  hyp_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid && inv_stage != 2'b00 |-> hyp_en);

  // R6
  one_fence_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sb_drain_req, walk_hold, illegal_trap}));

endmodule

// File: tb/tb_tlb_inval_seq.sv
module tb_tlb_inval_seq;
  localparam int XLEN = 64, ID_W = 16, CNT_W = 4;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic             insn_valid = 0;
  logic [31:0]      insn = 0;
  logic [XLEN-1:0]  rs1_val = 0, rs2_val = 0;
  logic [1:0]       priv = 2'b01;
  logic             tvm = 0, hyp_en = 1, inv_ready = 1, sb_drained = 0;
  logic [CNT_W-1:0] inv_pending = 0;
  logic             insn_ready, busy, illegal_trap, inv_valid, inv_all_addr, inv_all_id;
  logic             sb_drain_req, walk_hold;
  logic [XLEN-1:0]  inv_addr;
  logic [ID_W-1:0]  inv_id;
  logic [1:0]       inv_stage;

  tlb_inval_seq #(.XLEN(XLEN), .ID_W(ID_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn(insn),
    .rs1_val(rs1_val), .rs2_val(rs2_val), .priv(priv), .tvm(tvm), .hyp_en(hyp_en),
    .insn_ready(insn_ready), .busy(busy), .illegal_trap(illegal_trap),
    .inv_valid(inv_valid), .inv_ready(inv_ready), .inv_addr(inv_addr), .inv_id(inv_id),
    .inv_stage(inv_stage), .inv_all_addr(inv_all_addr), .inv_all_id(inv_all_id),
    .inv_pending(inv_pending), .sb_drain_req(sb_drain_req), .sb_drained(sb_drained),
    .walk_hold(walk_hold));

  int errors = 0, checks = 0;
  string cur_req = "R1";
  int mstate = 0;
  bit finished = 0;

  localparam int K_NONE = 0, K_S = 1, K_VV = 2, K_GV = 3, K_W = 4, K_IR = 5, K_ILL = 6;

  function automatic logic [31:0] enc(logic [6:0] f7, int rs2, int rs1, int rd, logic [2:0] f3 = 3'b000, logic [6:0] op = 7'b1110011);
    return {f7, rs2[4:0], rs1[4:0], f3, rd[4:0], op};
  endfunction

  function automatic int classify();
    int k;
    if (!insn_valid || insn[6:0] != 7'h73 || insn[14:12] != 0) return K_NONE;
    case (insn[31:25])
      7'h0B: k = K_S;
      7'h13: k = K_VV;
      7'h33: k = K_GV;
      7'h0C: k = (insn[24:20] == 0) ? K_W : (insn[24:20] == 1) ? K_IR : K_ILL;
      default: return K_NONE;
    endcase
    if (insn[11:7] != 0 || priv == 2'b00) return K_ILL;
    if (k == K_S && priv == 2'b01 && tvm) return K_ILL;
    if ((k == K_VV || k == K_GV) && !hyp_en) return K_ILL;
    return k;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) mstate = 0;
    else begin
      int k;
      k = classify();
      if (mstate == 0) begin
        if (k == K_W) mstate = 1;
        else if (k == K_IR) mstate = 2;
      end else if (mstate == 1) begin
        if (sb_drained) mstate = 0;
      end else if (inv_pending == 0) mstate = 0;
    end
  end

  task automatic chk(string nm, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", cur_req, nm, act, exp);
    end
  endtask

  task automatic check();
    int k;
    bit isinv;
    k = classify();
    isinv = (k == K_S || k == K_VV || k == K_GV);
    if (mstate == 0) begin
      chk("busy", busy, 0);
      chk("sb_drain_req", sb_drain_req, 0);
      chk("walk_hold", walk_hold, 0);
      chk("inv_valid", inv_valid, isinv);
      chk("illegal_trap", illegal_trap, k == K_ILL);
      chk("insn_ready", insn_ready, !(isinv && !inv_ready));
      if (isinv) begin
        chk("inv_addr", inv_addr, rs1_val);
        chk("inv_id", inv_id, rs2_val[ID_W-1:0]);
        chk("inv_stage", inv_stage, k == K_S ? 0 : (k == K_VV ? 1 : 2));
        chk("inv_all_addr", inv_all_addr, insn[19:15] == 0);
        chk("inv_all_id", inv_all_id, insn[24:20] == 0);
      end
    end else begin
      chk("busy", busy, 1);
      chk("insn_ready", insn_ready, 0);
      chk("inv_valid", inv_valid, 0);
      chk("illegal_trap", illegal_trap, 0);
      chk("sb_drain_req", sb_drain_req, mstate == 1);
      chk("walk_hold", walk_hold, mstate == 2);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) begin
      #2 check();
      @(negedge clk);
    end
  endtask

  task automatic put(logic [31:0] w, logic [63:0] a, logic [63:0] b);
    insn_valid = 1; insn = w; rs1_val = a; rs2_val = b;
  endtask

  task automatic quiet();
    insn_valid = 0; insn = 0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  localparam logic [6:0] S7 = 7'b0001011, F7 = 7'b0001100, V7 = 7'b0010011, G7 = 7'b0110011;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R1"; cyc(2);

    cur_req = "R2";
    put(enc(S7, 6, 5, 0), 64'h0000_7fff_1234_5000, 64'h0000_0000_0000_abcd); cyc(1);
    put(enc(S7, 0, 0, 0), 64'h0, 64'h0); cyc(1);
    put(enc(S7, 0, 9, 0), 64'h8000, 64'h77); cyc(1);
    quiet(); cyc(1);

    cur_req = "R3";
    put(enc(V7, 3, 4, 0), 64'h4000, 64'h0042); cyc(1);
    put(enc(G7, 7, 0, 0), 64'h0, 64'h0001_0009); cyc(1);
    quiet(); cyc(1);

    cur_req = "R4";
    inv_pending = 3;
    put(enc(S7, 1, 2, 0), 64'h1000, 64'h1); cyc(1);
    put(enc(S7, 1, 2, 0), 64'h2000, 64'h2); cyc(1);
    put(enc(V7, 1, 2, 0), 64'h3000, 64'h3); cyc(1);
    quiet(); cyc(1);

    cur_req = "R5";
    inv_ready = 0;
    put(enc(S7, 1, 2, 0), 64'h5000, 64'h5); cyc(3);
    inv_ready = 1; cyc(1);
    quiet(); cyc(1);

    cur_req = "R6";
    sb_drained = 0;
    put(enc(F7, 0, 0, 0), 64'h0, 64'h0); cyc(1);
    put(enc(S7, 1, 2, 0), 64'h6000, 64'h6); cyc(4);
    sb_drained = 1; cyc(1);
    sb_drained = 0; cyc(1);
    quiet(); cyc(1);

    cur_req = "R7";
    inv_pending = 2;
    put(enc(F7, 1, 0, 0), 64'h0, 64'h0); cyc(1);
    put(enc(S7, 1, 2, 0), 64'h7000, 64'h7); cyc(3);
    inv_pending = 0; cyc(1);
    cyc(1);
    quiet(); cyc(1);

    cur_req = "R8";
    priv = 2'b00;
    put(enc(S7, 1, 2, 0), 64'h1, 64'h1); cyc(1);
    put(enc(V7, 1, 2, 0), 64'h1, 64'h1); cyc(1);
    put(enc(G7, 1, 2, 0), 64'h1, 64'h1); cyc(1);
    put(enc(F7, 0, 0, 0), 64'h1, 64'h1); cyc(1);
    put(enc(F7, 1, 0, 0), 64'h1, 64'h1); cyc(1);
    quiet(); cyc(1);

    cur_req = "R9";
    priv = 2'b01; tvm = 1;
    put(enc(S7, 1, 2, 0), 64'h9, 64'h9); cyc(1);
    sb_drained = 1;
    put(enc(F7, 0, 0, 0), 64'h0, 64'h0); cyc(1);
    quiet(); cyc(1);
    put(enc(F7, 1, 0, 0), 64'h0, 64'h0); cyc(1);
    quiet(); cyc(1);
    sb_drained = 0;
    priv = 2'b11;
    put(enc(S7, 1, 2, 0), 64'h9, 64'h9); cyc(1);
    tvm = 0; priv = 2'b01;
    quiet(); cyc(1);

    cur_req = "R10";
    hyp_en = 0;
    put(enc(V7, 1, 2, 0), 64'ha, 64'ha); cyc(1);
    put(enc(G7, 1, 2, 0), 64'ha, 64'ha); cyc(1);
    put(enc(S7, 1, 2, 0), 64'ha, 64'ha); cyc(1);
    hyp_en = 1;
    quiet(); cyc(1);

    cur_req = "R11";
    put(enc(S7, 1, 2, 3), 64'hb, 64'hb); cyc(1);
    put(enc(F7, 0, 0, 1), 64'hb, 64'hb); cyc(1);
    put(enc(F7, 2, 0, 0), 64'hb, 64'hb); cyc(1);
    put(enc(F7, 31, 0, 0), 64'hb, 64'hb); cyc(1);
    quiet(); cyc(1);

    cur_req = "R12";
    put(enc(7'b0001001, 1, 2, 0), 64'hc, 64'hc); cyc(1);
    put(enc(S7, 1, 2, 0, 3'b001), 64'hc, 64'hc); cyc(1);
    put(enc(F7, 0, 0, 0, 3'b000, 7'b0110011), 64'hc, 64'hc); cyc(1);
    quiet(); cyc(2);

    summary();
  end
endmodule